// File: doc/BRIEF.md
# Measurement Mode and Rate Controller

This block holds the measurement configuration of a three-axis field sensor front end and turns it into a stream of measurement trigger strobes. Software writes a packed control byte that chooses standby or continuous operation, the output data rate, the field range and the oversampling ratio. A second control byte holds a self-clearing soft reset, a read-pointer wrap enable and an interrupt disable. A third byte holds a set/reset pulse period that is passed through to the analog side. A fixed identity byte reads back as all ones.

In continuous mode a divider counts pulses of a slow base tick and raises a one-cycle trigger every data-rate period. The range and oversampling codes that were current when the strobe fired travel with it, so the conversion logic downstream needs no other configuration input. In standby, and in the two reserved mode codes, the divider is held at zero and no trigger is raised. The conversion itself belongs to other logic.

Top module: `meas_ctrl_top`

## Requirements
- R1: After reset the control byte at 0x9, the control byte at 0xA and the period byte at 0xB all read 0x00, the block is in standby and no trigger is raised.
- R2: The byte at 0x9 is read/write and packs oversampling in bits 7:6 (00=512, 01=256, 10=128, 11=64), range in bits 5:4 (00=±2 G, 01=±8 G), data rate in bits 3:2 and mode in bits 1:0; the fields appear on the matching outputs and the whole byte reads back as written.
- R3: Only mode code 01 is continuous; with mode 00, 10 or 11 no trigger is ever raised, whatever the ticks.
- R4: In continuous mode a trigger follows every Nth base tick, where N is TICKS_10HZ for rate code 00, TICKS_10HZ/5 for 01, TICKS_10HZ/10 for 10 and TICKS_10HZ/20 for 11; the first trigger follows the Nth tick after continuous mode is entered.
- R5: A trigger is high for exactly one clock cycle, in the cycle after the base tick that completes the period, and carries on its range and oversampling outputs the bits 5:4 and 7:6 of the byte at 0x9 at that moment.
- R6: A change of the mode or rate field restarts the period count from zero; a write that changes only the range or oversampling fields leaves the count running.
- R7: The byte at 0xA keeps bit 6 (read-pointer wrap enable) and bit 0 (interrupt disable) and drives them on their outputs; all other bits, including bit 7, read back as 0.
- R8: A write to 0xA with bit 7 set returns 0x9, 0xA and 0xB to 0x00 at once, discards the rest of that write, and leaves the block in standby with no further trigger.
- R9: The byte at 0xB is read/write and drives the period output; address 0xD always reads 0xFF and ignores writes; any other address reads 0x00 and ignores writes.
- R10: Base ticks received while not in continuous mode are not counted, so the first trigger after entering continuous mode still needs a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_tick | input | 1 | One-cycle pulse of the slow timing base |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| meas_trig | output | 1 | One-cycle measurement trigger |
| trig_rng | output | 2 | Range code carried with the trigger |
| trig_osr | output | 2 | Oversampling code carried with the trigger |
| cont_en | output | 1 | High while the mode field is continuous |
| cfg_odr | output | 2 | Current rate field |
| cfg_rng | output | 2 | Current range field |
| cfg_osr | output | 2 | Current oversampling field |
| wrap_en | output | 1 | Read-pointer wrap enable |
| irq_dis | output | 1 | Interrupt disable |
| sr_period | output | 8 | Set/reset period byte |

## Verification
The divider is driven with each of the four rate codes in continuous mode and with the three non-continuous mode codes, so a wrong period table, an off-by-one terminal count or a reserved code decoded as active shows up as a trigger in the wrong tick. Rate or mode changes part way through a period are separated from range-only or oversampling-only writes, which tells a restart from a running count, and the trigger fields are compared after such writes. A soft reset is issued during continuous counting with other control bits set, which distinguishes a full clear from a partial one. Random sequences of writes, reads and tick bursts run alongside these directed cases against a tick-by-tick model.

// File: rtl/mc_pkg.sv
// Package: shared addresses, codes and the packed layout of the first control byte.
package mc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL1 = 4'h9;
    localparam logic [ADDR_W-1:0] ADDR_CTRL2 = 4'hA;
    localparam logic [ADDR_W-1:0] ADDR_SRPER = 4'hB;
    localparam logic [ADDR_W-1:0] ADDR_IDENT = 4'hD;
    localparam logic [DATA_W-1:0] IDENT_VAL  = 8'hFF;

    localparam int BIT_SRST = 7;
    localparam int BIT_WRAP = 6;
    localparam int BIT_IRQD = 0;

    typedef enum logic [1:0] {
        MODE_STBY = 2'b00,
        MODE_CONT = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_RSV3 = 2'b11
    } mode_e;

    typedef struct packed {
        logic [1:0] osr;
        logic [1:0] rng;
        logic [1:0] odr;
        logic [1:0] mode;
    } ctrl1_t;
endpackage

// File: rtl/mc_regfile.sv
// Module: mc_regfile
// Holds the two control bytes and the set/reset period byte, decodes writes,
// applies the self-clearing soft reset and serves combinational reads.
// Assumes one write per strobe cycle; reads have no side effects.
module mc_regfile
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl1_t            ctrl1,
    output logic              wrap_en,
    output logic              irq_dis,
    output logic [DATA_W-1:0] sr_period
);
    logic wr_c1, wr_c2, wr_per, soft_rst;

    // Write decode, with the soft reset taking precedence inside ctrl2 writes.
    always_comb begin
        wr_c1    = wr_en && (addr == ADDR_CTRL1);
        wr_c2    = wr_en && (addr == ADDR_CTRL2);
        wr_per   = wr_en && (addr == ADDR_SRPER);
        soft_rst = wr_c2 && wdata[BIT_SRST];
    end

    // Register update: hard or soft reset clears everything, else field writes.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl1     <= '0;
            wrap_en   <= 1'b0;
            irq_dis   <= 1'b0;
            sr_period <= '0;
        end else begin
            if (wr_c1) ctrl1 <= ctrl1_t'(wdata);
            if (wr_c2) begin
                wrap_en <= wdata[BIT_WRAP];
                irq_dis <= wdata[BIT_IRQD];
            end
            if (wr_per) sr_period <= wdata;
        end
    end

    // Read mux; the soft reset bit is never stored, so it reads as zero.
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL1: rdata = ctrl1;
            ADDR_CTRL2: begin
                rdata[BIT_WRAP] = wrap_en;
                rdata[BIT_IRQD] = irq_dis;
            end
            ADDR_SRPER: rdata = sr_period;
            ADDR_IDENT: rdata = IDENT_VAL;
            default:    rdata = '0;
        endcase
    end

    p_srst_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CTRL2 && wdata[BIT_SRST])
        |=> (ctrl1 == '0 && !wrap_en && !irq_dis && sr_period == '0));

    p_ctrl1_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == ADDR_CTRL1 || addr == ADDR_CTRL2)) |=> $stable(ctrl1));

    p_per_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == ADDR_SRPER || addr == ADDR_CTRL2)) |=> $stable(sr_period));
endmodule

// File: rtl/mc_rate_div.sv
// Module: mc_rate_div
// Counts base ticks while continuous mode is active and fires a one-cycle
// trigger each data-rate period, latching range and oversampling with it.
// Assumes TICKS_10HZ is a multiple of 20 and at least 40, so every period is
// two ticks or more. A tick in the cycle right after a mode or rate change is lost.
module mc_rate_div #(
    parameter int TICKS_10HZ = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       active_i,
    input  logic [1:0] odr_i,
    input  logic [1:0] rng_i,
    input  logic [1:0] osr_i,
    output logic       fire_o,
    output logic [1:0] fire_rng_o,
    output logic [1:0] fire_osr_o
);
    localparam int CNT_W   = $clog2(TICKS_10HZ);
    localparam int PER_10  = TICKS_10HZ;
    localparam int PER_50  = TICKS_10HZ / 5;
    localparam int PER_100 = TICKS_10HZ / 10;
    localparam int PER_200 = TICKS_10HZ / 20;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;
    logic [2:0]       prev_cfg;
    logic             restart;

    // Terminal count for the selected rate code.
    always_comb begin
        unique case (odr_i)
            2'b00:   last_cnt = CNT_W'(PER_10 - 1);
            2'b01:   last_cnt = CNT_W'(PER_50 - 1);
            2'b10:   last_cnt = CNT_W'(PER_100 - 1);
            default: last_cnt = CNT_W'(PER_200 - 1);
        endcase
        restart = (prev_cfg != {active_i, odr_i});
    end

    // Divider: held at zero when idle or on a config change, else counts ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            prev_cfg   <= '0;
            fire_o     <= 1'b0;
            fire_rng_o <= '0;
            fire_osr_o <= '0;
        end else begin
            fire_o   <= 1'b0;
            prev_cfg <= {active_i, odr_i};
            if (!active_i || restart) begin
                cnt <= '0;
            end else if (tick_i) begin
                if (cnt == last_cnt) begin
                    cnt        <= '0;
                    fire_o     <= 1'b1;
                    fire_rng_o <= rng_i;
                    fire_osr_o <= osr_i;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_trig_cont_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(active_i));

    p_trig_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(tick_i));

    p_trig_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    p_idle_no_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (cnt == '0 && !fire_o));
endmodule

// File: rtl/meas_ctrl_top.sv
// Module: meas_ctrl_top
// Measurement mode and rate controller: register bank plus trigger divider.
// Only mode code 01 enables the divider; reserved codes behave as standby.
// Assumes base_tick is a single-cycle pulse far slower than clk.
module meas_ctrl_top
    import mc_pkg::*;
#(
    parameter int TICKS_10HZ = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       reg_wr,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       meas_trig,
    output logic [1:0] trig_rng,
    output logic [1:0] trig_osr,
    output logic       cont_en,
    output logic [1:0] cfg_odr,
    output logic [1:0] cfg_rng,
    output logic [1:0] cfg_osr,
    output logic       wrap_en,
    output logic       irq_dis,
    output logic [7:0] sr_period
);
    ctrl1_t ctrl1;

    mc_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ctrl1     (ctrl1),
        .wrap_en   (wrap_en),
        .irq_dis   (irq_dis),
        .sr_period (sr_period)
    );

    // Field fan-out; reserved mode codes decode to inactive.
    always_comb begin
        cont_en = (mode_e'(ctrl1.mode) == MODE_CONT);
        cfg_odr = ctrl1.odr;
        cfg_rng = ctrl1.rng;
        cfg_osr = ctrl1.osr;
    end

    mc_rate_div #(.TICKS_10HZ(TICKS_10HZ)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (base_tick),
        .active_i   (cont_en),
        .odr_i      (ctrl1.odr),
        .rng_i      (ctrl1.rng),
        .osr_i      (ctrl1.osr),
        .fire_o     (meas_trig),
        .fire_rng_o (trig_rng),
        .fire_osr_o (trig_osr)
    );

    p_srst_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL2 && reg_wdata[BIT_SRST]) |=> (!cont_en && !meas_trig));
endmodule

// File: tb/sim_meas_ctrl_top.sv
// Bench: tick-by-tick model of the divider and shadow registers, directed
// corner cases followed by seeded random write/read/tick sequences.
module sim_meas_ctrl_top;
    localparam int TK = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       meas_trig;
    logic [1:0] trig_rng, trig_osr, cfg_odr, cfg_rng, cfg_osr;
    logic       cont_en, wrap_en, irq_dis;
    logic [7:0] sr_period;

    int n_chk = 0;
    int n_err = 0;

    // model state
    logic [7:0] m_c1 = '0;
    logic       m_wrap = 0, m_irqd = 0;
    logic [7:0] m_per = '0;
    int         m_cnt = 0;

    always #2.5 clk = ~clk;

    meas_ctrl_top #(.TICKS_10HZ(TK)) u0 (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .meas_trig(meas_trig), .trig_rng(trig_rng), .trig_osr(trig_osr),
        .cont_en(cont_en), .cfg_odr(cfg_odr), .cfg_rng(cfg_rng), .cfg_osr(cfg_osr),
        .wrap_en(wrap_en), .irq_dis(irq_dis), .sr_period(sr_period)
    );

    function automatic int period_of(input logic [1:0] odr);
        case (odr)
            2'b00: return TK;
            2'b01: return TK / 5;
            2'b10: return TK / 10;
            default: return TK / 20;
        endcase
    endfunction

    function automatic logic m_active();
        return m_c1[1:0] == 2'b01;
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'h9: return m_c1;
            4'hA: return {1'b0, m_wrap, 5'b0, m_irqd};
            4'hB: return m_per;
            4'hD: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One write cycle plus two idle cycles; model follows the requirements.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] old;
        old = m_c1;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 4'h9) m_c1 = d;
        else if (a == 4'hA) begin
            if (d[7]) begin m_c1 = '0; m_wrap = 0; m_irqd = 0; m_per = '0; end
            else begin m_wrap = d[6]; m_irqd = d[0]; end
        end else if (a == 4'hB) m_per = d;
        if ((old[1:0] == 2'b01) != (m_c1[1:0] == 2'b01) || old[3:2] != m_c1[3:2]) m_cnt = 0;
        if (!m_active()) m_cnt = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp_read(a), tag, reg_rdata, exp_read(a));
    endtask

    // One base tick; trigger checked in the cycle after the tick edge.
    task automatic tk(input string tag);
        logic exp_t;
        exp_t = 1'b0;
        @(negedge clk);
        base_tick = 1'b1;
        if (m_active()) begin
            if (m_cnt == period_of(m_c1[3:2]) - 1) begin m_cnt = 0; exp_t = 1'b1; end
            else m_cnt++;
        end
        @(negedge clk);
        base_tick = 1'b0;
        chk(meas_trig == exp_t, tag, meas_trig, exp_t);
        if (exp_t) begin
            chk(trig_rng == m_c1[5:4], "R5 trig_rng", trig_rng, m_c1[5:4]);
            chk(trig_osr == m_c1[7:6], "R5 trig_osr", trig_osr, m_c1[7:6]);
            @(negedge clk);
            chk(meas_trig == 1'b0, "R5 one-cycle trigger", meas_trig, 0);
        end
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) tk(tag);
    endtask

    // Counts ticks to the first trigger after a fresh entry into continuous mode.
    task automatic first_trig_len(input logic [1:0] odr, input string tag);
        int got;
        got = 0;
        wr(4'h9, 8'h00);
        wr(4'h9, {4'b0000, odr, 2'b01});
        for (int i = 0; i < 2 * TK; i++) begin
            @(negedge clk); base_tick = 1'b1;
            @(negedge clk); base_tick = 1'b0;
            got++;
            if (meas_trig) break;
        end
        chk(got == period_of(odr), tag, got, period_of(odr));
        m_cnt = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h9, "R1 ctrl1 default");
        rd(4'hA, "R1 ctrl2 default");
        rd(4'hB, "R1 period default");
        ticks(TK + 2, "R1 no trigger after reset");

        // R2 field layout: OSR 512, 8 G, fastest rate, continuous
        wr(4'h9, 8'h1D);
        rd(4'h9, "R2 ctrl1 readback");
        chk({cfg_osr, cfg_rng, cfg_odr, cont_en} == 7'b00_01_11_1, "R2 field outputs",
            {cfg_osr, cfg_rng, cfg_odr, cont_en}, 7'b00_01_11_1);
        ticks(7, "R4 200Hz stream");

        // R3 reserved and standby modes never trigger
        wr(4'h9, 8'h0E); ticks(TK + 3, "R3 mode 10");
        wr(4'h9, 8'h0F); ticks(TK + 3, "R3 mode 11");
        wr(4'h9, 8'h0C); ticks(TK + 3, "R3 mode 00");

        // R4 each rate code, first trigger one full period after entry
        first_trig_len(2'b00, "R4 period code 00");
        first_trig_len(2'b01, "R4 period code 01");
        first_trig_len(2'b10, "R4 period code 10");
        first_trig_len(2'b11, "R4 period code 11");

        // R10 ticks in standby are not banked
        wr(4'h9, 8'h00);
        ticks(TK / 5 - 1, "R10 standby ticks");
        wr(4'h9, 8'h05);
        ticks(TK / 5 - 1, "R10 no early trigger");
        ticks(1, "R10 full period trigger");

        // R6 rate change mid-period restarts; range/osr change does not
        wr(4'h9, 8'h01);
        ticks(TK - 3, "R6 partial period");
        wr(4'h9, 8'h05);
        ticks(TK / 5 + 1, "R6 restart after rate change");
        ticks(3, "R6 before range write");
        wr(4'h9, 8'hD5);
        ticks(TK / 5 + 2, "R6 count kept over range write");

        // R7 second control byte
        wr(4'hA, 8'h7F);
        rd(4'hA, "R7 ctrl2 readback");
        chk({wrap_en, irq_dis} == 2'b11, "R7 ctrl2 outputs", {wrap_en, irq_dis}, 3);

        // R9 period byte, identity byte, unmapped addresses
        wr(4'hB, 8'h01); rd(4'hB, "R9 period rw");
        chk(sr_period == 8'h01, "R9 period output", sr_period, 1);
        wr(4'hD, 8'h12); rd(4'hD, "R9 identity");
        wr(4'h3, 8'h55); rd(4'h3, "R9 unmapped");
        rd(4'h9, "R9 unmapped write ignored");

        // R8 soft reset during continuous counting, other bits set
        wr(4'h9, 8'h5D);
        ticks(1, "R8 before soft reset");
        wr(4'hA, 8'hC1);
        rd(4'h9, "R8 ctrl1 cleared");
        rd(4'hA, "R8 ctrl2 cleared");
        rd(4'hB, "R8 period cleared");
        chk(cont_en == 1'b0, "R8 standby", cont_en, 0);
        ticks(TK + 1, "R8 no trigger after soft reset");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4) wr(4'h9, 8'($urandom_range(0, 255)));
            else if (k == 4) wr(4'($urandom_range(0, 15)), 8'($urandom_range(0, 127)));
            else if (k == 5) rd(4'($urandom_range(0, 15)), "R9 random read");
            else ticks($urandom_range(1, 30), "R4 random ticks");
        end
        wr(4'hA, 8'h80);
        rd(4'h9, "R8 final soft reset");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule